// File: doc/BRIEF.md
# Delay Tap Value Controller

This block keeps the 5-bit tap number that selects the length of an output delay line. It does not model the delay line. It only produces the integer that would steer it. The behaviour is chosen at elaboration time from four operating modes. A fixed mode holds a preset tap. A stepping mode moves the tap up or down one tap per enabled edge and returns to the preset on a load. A direct-load mode takes a new tap from a 5-bit input. A staged-load mode first captures that input into a holding register, then moves it into the tap on a later load.

The mode and the preset tap are parameters. At run time the block is driven by a load strobe, a step enable, a direction select, a 5-bit load value and a capture strobe. It reports the current tap and, for observation, the holding register. The reset input is active low and asserts asynchronously. Its release is synchronised to the clock inside the block, so the tap leaves its starting value only from the second rising edge after `rst_n` goes high.

Top module: `dly_tap_ctl`

## Requirements
- R1: While reset is active, and after its release until the first control action, `tap` equals the start value and `pipe_q` is 0. The start value is `PRESET` in fixed and stepping modes (mode codes 0 and 1) and 0 in direct-load and staged-load modes (codes 2 and 3).
- R2: In fixed mode `tap` stays equal to `PRESET` on every cycle, whatever `ld`, `ce`, `inc`, `ld_val` and `cap` do.
- R3: In stepping mode, a rising edge with `ld` high sets `tap` to `PRESET`.
- R4: In stepping, direct-load and staged-load modes, a rising edge with `ld` low and `ce` high moves `tap` by one. It adds 1 when `inc` is high and subtracts 1 when `inc` is low.
- R5: In every non-fixed mode, a rising edge with `ld` and `ce` both low leaves `tap` unchanged.
- R6: Stepping wraps around: up from 31 gives 0, and down from 0 gives 31.
- R7: In direct-load mode, a rising edge with `ld` high sets `tap` to `ld_val`.
- R8: In staged-load mode, a rising edge with `cap` high stores `ld_val` into the holding register shown on `pipe_q`. With `cap` low, `pipe_q` keeps its value.
- R9: In staged-load mode, a rising edge with `ld` high sets `tap` to the value `pipe_q` held before that edge, even when `cap` is high on the same edge.
- R10: In every non-fixed mode `ld` wins over `ce`: when both are high, `tap` takes the load value and does not step.
- R11: In every mode other than staged-load, `pipe_q` stays 0 and `cap` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld | input | 1 | Load strobe (preset, direct value or staged value, by mode) |
| ce | input | 1 | Step enable |
| inc | input | 1 | Step direction: 1 up, 0 down |
| ld_val | input | TAP_W (5) | Value for direct load or for capture |
| cap | input | 1 | Capture strobe for the holding register |
| tap | output | TAP_W (5) | Current tap number |
| pipe_q | output | TAP_W (5) | Holding register contents |

## Verification
The hardest case to reach is in staged-load mode, where a load and a capture land on the same edge. The tap must then take the old holding value while the new input goes into the register. Random stimulus seldom builds the needed history of a known capture followed by a same-edge load and a different input. For that reason a directed sequence first captures one value and then pulses `ld` and `cap` together with a second value. The wrap corners are handled the same way: the stepping instance starts from a preset of 21, is walked up past 31 and back down past 0, and the direct-load instance is loaded with 31 and stepped. All four mode variants share one random stream with a low load rate, and a mid-run reset checks that the asynchronous assertion takes effect at once.

// File: rtl/dly_tap_pkg.sv
package dly_tap_pkg;

  // Operating variants; codes 0..3
  typedef enum logic [1:0] {
    TAP_FIXED  = 2'd0,
    TAP_STEP   = 2'd1,
    TAP_DIRECT = 2'd2,
    TAP_PIPED  = 2'd3
  } tap_mode_e;

  function automatic bit mode_has_preset(tap_mode_e m);
    return (m == TAP_FIXED) || (m == TAP_STEP);
  endfunction

endpackage

// File: rtl/dly_rst_sync.sv
module dly_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  // shift chain fed with constant one
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign sh_d[i] = 1'b1;
      end else begin : g_body
        assign sh_d[i] = sh_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];

endmodule

// File: rtl/dly_tap_hold.sv
module dly_tap_hold #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (cap_en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) q <= '0;
    else          q <= q_d;
  end

endmodule

// File: rtl/dly_tap_next.sv
module dly_tap_next #(
  parameter int                    W      = 5,
  parameter dly_tap_pkg::tap_mode_e MODE   = dly_tap_pkg::TAP_STEP,
  parameter int                    PRESET = 0
) (
  input  logic         ld,
  input  logic         ce,
  input  logic         inc,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] pipe_val,
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         upd
);

  localparam logic [W-1:0] PRE_V = W'(PRESET);

  logic [W-1:0] load_v;
  logic [W-1:0] step_v;

  // source of a load, chosen by mode
  always_comb begin
    unique case (MODE)
      dly_tap_pkg::TAP_STEP:   load_v = PRE_V;
      dly_tap_pkg::TAP_DIRECT: load_v = ld_val;
      dly_tap_pkg::TAP_PIPED:  load_v = pipe_val;
      default:                 load_v = PRE_V;
    endcase
  end

  // modulo-2^W step, one adder shared by both directions
  assign step_v = cur + (inc ? W'(1) : {W{1'b1}});

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    if (MODE != dly_tap_pkg::TAP_FIXED) begin
      if (ld) begin
        nxt = load_v;
        upd = 1'b1;
      end else if (ce) begin
        nxt = step_v;
        upd = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dly_tap_ctl.sv
module dly_tap_ctl #(
  parameter int                    TAP_W  = 5,
  parameter dly_tap_pkg::tap_mode_e MODE   = dly_tap_pkg::TAP_STEP,
  parameter int                    PRESET = 0,
  parameter int                    SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             ce,
  input  logic             inc,
  input  logic [TAP_W-1:0] ld_val,
  input  logic             cap,
  output logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] pipe_q
);

  localparam bit           USE_PRE = dly_tap_pkg::mode_has_preset(MODE);
  localparam logic [TAP_W-1:0] START = USE_PRE ? TAP_W'(PRESET) : '0;
  localparam bit           USE_CAP = (MODE == dly_tap_pkg::TAP_PIPED);

  logic             rst_q_n;
  logic [TAP_W-1:0] tap_d;
  logic             tap_en;

  dly_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dly_tap_hold #(.W(TAP_W)) u_hold (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .cap_en  (cap & USE_CAP),
    .d       (ld_val),
    .q       (pipe_q)
  );

  dly_tap_next #(.W(TAP_W), .MODE(MODE), .PRESET(PRESET)) u_next (
    .ld       (ld),
    .ce       (ce),
    .inc      (inc),
    .ld_val   (ld_val),
    .pipe_val (pipe_q),
    .cur      (tap),
    .nxt      (tap_d),
    .upd      (tap_en)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    tap <= START;
    else if (tap_en) tap <= tap_d;
  end

endmodule

// File: rtl/dly_tap_chk.sv
module dly_tap_chk #(
  parameter int                    TAP_W  = 5,
  parameter dly_tap_pkg::tap_mode_e MODE   = dly_tap_pkg::TAP_STEP,
  parameter int                    PRESET = 0
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             ld,
  input logic             ce,
  input logic             inc,
  input logic [TAP_W-1:0] ld_val,
  input logic             cap,
  input logic [TAP_W-1:0] tap,
  input logic [TAP_W-1:0] pipe_q
);

  localparam logic [TAP_W-1:0] PRE_V = TAP_W'(PRESET);

  logic armed;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  assert_known_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    armed |-> !$isunknown({tap, pipe_q, ld, ce, inc, ld_val, cap}));

  if (MODE == dly_tap_pkg::TAP_FIXED) begin : g_fix
    assert_fixed_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed |-> tap == PRE_V);
  end else begin : g_var
    // R4 and R6: modulo stepping
    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && !ld && ce && inc |=> tap == TAP_W'($past(tap) + TAP_W'(1)));
    assert_step_dn_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && !ld && ce && !inc |=> tap == TAP_W'($past(tap) - TAP_W'(1)));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && !ld && !ce |=> $stable(tap));
  end

  if (MODE == dly_tap_pkg::TAP_STEP) begin : g_step
    assert_preset_load_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && ld |=> tap == PRE_V);
  end

  if (MODE == dly_tap_pkg::TAP_DIRECT) begin : g_dir
    assert_direct_load_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && ld |=> tap == $past(ld_val));
  end

  if (MODE == dly_tap_pkg::TAP_PIPED) begin : g_pip
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && cap |=> pipe_q == $past(ld_val));
    assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && !cap |=> $stable(pipe_q));
    assert_staged_load_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed && ld |=> tap == $past(pipe_q));
  end else begin : g_nopip
    assert_pipe_zero_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
      armed |-> pipe_q == '0);
  end

endmodule

bind dly_tap_ctl dly_tap_chk #(.TAP_W(TAP_W), .MODE(MODE), .PRESET(PRESET)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .ld      (ld),
  .ce      (ce),
  .inc     (inc),
  .ld_val  (ld_val),
  .cap     (cap),
  .tap     (tap),
  .pipe_q  (pipe_q)
);

// File: tb/sim_dly_tap_ctl.sv
`timescale 1ns/1ps
module sim_dly_tap_ctl;
  import dly_tap_pkg::*;

  localparam int W = 5;
  localparam int PRE_STEP = 21;
  localparam int PRE_FIX  = 9;
  localparam int PRE_LOAD = 17;

  logic clk = 1'b0;
  logic rst_n;
  logic ld, ce, inc, cap;
  logic [W-1:0] ld_val;
  logic [W-1:0] tap_s, tap_f, tap_d, tap_p;
  logic [W-1:0] pq_s, pq_f, pq_d, pq_p;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_tap [4];
  logic [W-1:0] m_pipe;

  always #2.5 clk = ~clk;

  dly_tap_ctl #(.TAP_W(W), .MODE(TAP_STEP), .PRESET(PRE_STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ce(ce), .inc(inc), .ld_val(ld_val),
    .cap(cap), .tap(tap_s), .pipe_q(pq_s));
  dly_tap_ctl #(.TAP_W(W), .MODE(TAP_FIXED), .PRESET(PRE_FIX)) u1 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ce(ce), .inc(inc), .ld_val(ld_val),
    .cap(cap), .tap(tap_f), .pipe_q(pq_f));
  dly_tap_ctl #(.TAP_W(W), .MODE(TAP_DIRECT), .PRESET(PRE_LOAD)) u2 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ce(ce), .inc(inc), .ld_val(ld_val),
    .cap(cap), .tap(tap_d), .pipe_q(pq_d));
  dly_tap_ctl #(.TAP_W(W), .MODE(TAP_PIPED), .PRESET(PRE_LOAD)) u3 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ce(ce), .inc(inc), .ld_val(ld_val),
    .cap(cap), .tap(tap_p), .pipe_q(pq_p));

  function automatic logic [W-1:0] exp_next(tap_mode_e m, logic [W-1:0] cur,
      int pre, logic l, logic c, logic up, logic [W-1:0] v, logic [W-1:0] pv);
    if (m == TAP_FIXED) return W'(pre);
    if (l) begin
      if (m == TAP_STEP)   return W'(pre);
      if (m == TAP_DIRECT) return v;
      return pv;
    end
    if (c) return up ? W'(cur + 1) : W'(cur - 1);
    return cur;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_tap[0] = W'(PRE_STEP);
    m_tap[1] = W'(PRE_FIX);
    m_tap[2] = '0;
    m_tap[3] = '0;
    m_pipe   = '0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R3/R4 step"},   tap_s, m_tap[0]);
    chk({tag, " R2 fixed"},     tap_f, m_tap[1]);
    chk({tag, " R7 direct"},    tap_d, m_tap[2]);
    chk({tag, " R9 staged"},    tap_p, m_tap[3]);
    chk({tag, " R8 pipe"},      pq_p,  m_pipe);
    chk({tag, " R11 pipe0"},    pq_s | pq_f | pq_d, '0);
  endtask

  // one clocked action: drive at falling edge, check just after rising edge
  task automatic cyc(logic l, logic c, logic up, logic [W-1:0] v, logic cp, string tag);
    @(negedge clk);
    ld = l; ce = c; inc = up; ld_val = v; cap = cp;
    @(posedge clk);
    m_tap[0] = exp_next(TAP_STEP,   m_tap[0], PRE_STEP, l, c, up, v, m_pipe);
    m_tap[1] = exp_next(TAP_FIXED,  m_tap[1], PRE_FIX,  l, c, up, v, m_pipe);
    m_tap[2] = exp_next(TAP_DIRECT, m_tap[2], PRE_LOAD, l, c, up, v, m_pipe);
    m_tap[3] = exp_next(TAP_PIPED,  m_tap[3], PRE_LOAD, l, c, up, v, m_pipe);
    if (cp) m_pipe = v;
    #1;
    check_all(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    ld = 0; ce = 0; inc = 0; cap = 0; ld_val = '0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 0; ld = 0; ce = 0; inc = 0; cap = 0; ld_val = '0;
    model_reset();
    repeat (4) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    // R6: walk the stepping instance 21 -> 31 -> 0 -> 31
    for (int i = 0; i < 11; i++) cyc(0, 1, 1, 5'd3, 0, "R4 up");
    chk("R6 wrap up", tap_s, 5'd0);
    cyc(0, 1, 0, 5'd3, 0, "R6 wrap down");
    chk("R6 wrap down", tap_s, 5'd31);
    // R5 hold with ld/ce low, cap low
    cyc(0, 0, 1, 5'd12, 0, "R5 hold");
    // R10: load with ce high; direct gets 31, then step up wraps
    cyc(1, 1, 0, 5'd31, 0, "R10 ld beats ce");
    chk("R10 direct", tap_d, 5'd31);
    chk("R3 preset", tap_s, 5'(PRE_STEP));
    cyc(0, 1, 1, 5'd0, 0, "R6 direct wrap");
    chk("R6 direct wrap", tap_d, 5'd0);
    // R8/R9: capture 13, then load with simultaneous capture of 7
    cyc(0, 0, 0, 5'd13, 1, "R8 capture");
    chk("R8 capture", pq_p, 5'd13);
    cyc(1, 0, 0, 5'd7, 1, "R9 same-edge");
    chk("R9 old pipe", tap_p, 5'd13);
    chk("R8 new pipe", pq_p, 5'd7);
    chk("R11 no capture", pq_d, 5'd0);
    // R2 fixed under all activity
    chk("R2 fixed", tap_f, 5'(PRE_FIX));

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc((r[2:0] == 3'd0), r[3], 1'($urandom), 5'($urandom), ($urandom % 4 == 0), "rand");
    end

    // mid-run asynchronous reset: takes effect without a clock edge
    @(negedge clk);
    ld = 0; ce = 0; cap = 0;
    #0.5 rst_n = 0;
    #0.5;
    model_reset();
    check_all("R1 async assert");
    idle(2);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1 second release");
    for (int i = 0; i < 200; i++)
      cyc(($urandom % 5 == 0), 1'($urandom), 1'($urandom), 5'($urandom), 1'($urandom), "rand2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule